// File: doc/BRIEF.md
# Parallel Speculative Instruction Length Decoder

This block receives a window of instruction bytes fetched from memory and, in one clock cycle, finds where every variable-length instruction in that window begins and how many bytes it occupies. It does not step through the instructions one after another. It first works out a length at every byte position at once, as though an instruction started at each of them. A single first-to-last resolution pass then follows the real instruction boundaries from the entry offset onward, keeps the lengths at those positions and discards all the others.

The length of each instruction is read from a short run of header bytes at its start. Each header byte can ask for the byte after it to be read as well, and each header byte that is read adds a contribution to the length. The window does not have to begin on an instruction boundary: an entry offset left over from the previous window says where the first instruction starts. The block reports where decoding should resume in the next window. If an instruction's header is cut off at the end of the window, the block also says how many of that header's bytes were present.

A fetch unit drives one window per cycle with a valid strobe. The start mask, the per-position lengths and the resume information appear together, registered, on the following cycle.

Top module: `ild_top`

## Requirements
- R1: Byte encoding. Header bytes are read from an instruction's first byte upward, at most HDR_MAX of them (4 by default). Bit 7 of a header byte set means the next byte is also a header byte; bit 7 of the last allowed header byte has no effect. Bits 1:0 of a header byte hold a payload count. Each header byte read contributes 1 plus its payload count, so a length lies between 1 and 16.
- R2: The first instruction starts at the entry offset `i_carry_off` (0 to 15). No start is marked below that position.
- R3: Every later start lies exactly one instruction length after the previous start. A byte inside an instruction is never marked as a start.
- R4: `o_len` holds, in field p (bits p*5 +: 5), the length of the instruction starting at byte p when bit p of `o_start_mask` is set, and zero at every position that is not a start.
- R5: When the last instruction whose header is fully inside the window ends at or past the window end, `o_split` is 0 and `o_next_off` equals that instruction's start plus its length minus the window size.
- R6: When the resolution pass reaches a position whose required header bytes run past the window end, that position is not marked, `o_split` is 1 and `o_next_off` holds the number of bytes from that position to the window end (1 to 3).
- R7: Outputs and `o_valid` change one cycle after a window is presented with `i_valid` high. While `i_valid` is low, `o_valid` drops the next cycle and the other outputs keep their values.
- R8: A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | A window is presented this cycle |
| i_bytes | input | WIN_BYTES*8 | Window bytes, byte p at bits p*8 +: 8 |
| i_carry_off | input | 4 | Entry offset of the first instruction |
| o_valid | output | 1 | Registered copy of `i_valid` |
| o_start_mask | output | WIN_BYTES | Bit p set when an instruction starts at byte p |
| o_len | output | WIN_BYTES*5 | Per-position length, zero where no start |
| o_next_off | output | 4 | Resume offset in the next window, or the header bytes present when split |
| o_split | output | 1 | The last instruction's header is cut off by the window end |

## Verification
Windows of zero bytes give a length of one everywhere, so they check that every position after the entry offset is chained. Windows in which every byte asks for the next and carries the largest payload give maximal 16-byte instructions, which tests the longest hops and the exact end-of-window arithmetic for several entry offsets. Hand-built windows check the capped fourth header byte, a mixed-contribution sum and a header cut off at the window end. Random windows with sparse or dense continuation bits, random entry offsets and gaps in the valid strobe are compared, on every cycle, against a model that decodes one instruction at a time. This separates chaining errors from per-position length errors and from hold behaviour.

// File: rtl/ild_pkg.sv
// Package: shared byte-level constants for the instruction length decoder.
// Assumes byte-wide instruction memory and a continuation flag in the top bit.
package ild_pkg;
    localparam int ILD_BYTE_W   = 8;
    localparam int ILD_CONT_BIT = 7;
endpackage

// File: rtl/ild_byte_len.sv
// Module: ild_byte_len
// Computes the speculative length of an instruction assumed to start at one
// byte position. Reads up to HDR_MAX header bytes, following the continuation
// flag, and sums 1 + payload count for each byte read. VIS gives how many of the
// supplied header bytes really lie inside the window; if a needed byte is not
// visible, o_full is cleared and the length is only a partial sum.
// Assumes bytes beyond VIS are supplied as don't-care (tied off by the parent).
module ild_byte_len
    import ild_pkg::*;
#(
    parameter int HDR_MAX = 4,
    parameter int PAY_W   = 2,
    parameter int VIS     = 4,
    parameter int LEN_W   = 5
) (
    input  logic [HDR_MAX*ILD_BYTE_W-1:0] i_hdr,
    output logic [LEN_W-1:0]              o_len,
    output logic                          o_full
);

    logic unused_hdr_bits;
    assign unused_hdr_bits = ^i_hdr;

    // Walk the header bytes in order, accumulating contributions.
    always_comb begin
        logic                 want;
        logic [ILD_BYTE_W-1:0] cur;
        o_len  = '0;
        o_full = 1'b1;
        want   = 1'b1;
        for (int k = 0; k < HDR_MAX; k++) begin
            cur = i_hdr[k*ILD_BYTE_W +: ILD_BYTE_W];
            if (want) begin
                if (k >= VIS) begin
                    o_full = 1'b0;
                    want   = 1'b0;
                end else begin
                    o_len = o_len + LEN_W'(1) + LEN_W'(cur[PAY_W-1:0]);
                    want  = (k < HDR_MAX - 1) && cur[ILD_CONT_BIT];
                end
            end
        end
    end

endmodule

// File: rtl/ild_chain.sv
// Module: ild_chain
// Resolves the true instruction starts from the speculative per-position
// lengths. A position is reached if it equals the entry offset or if a reached,
// complete position k bytes earlier has length exactly k. Reached complete
// positions are starts. The reached position whose instruction crosses the
// window end (or whose header is cut off) sets the resume information.
// Assumes exactly one resolution path exists, which holds since each reached
// complete position reaches exactly one later position.
module ild_chain #(
    parameter int WIN_BYTES = 64,
    parameter int MAX_LEN   = 16,
    parameter int LEN_W     = 5,
    parameter int OFF_W     = 4
) (
    input  logic [WIN_BYTES*LEN_W-1:0] i_lens,
    input  logic [WIN_BYTES-1:0]       i_full,
    input  logic [OFF_W-1:0]           i_carry,
    output logic [WIN_BYTES-1:0]       o_start,
    output logic                       o_split,
    output logic [OFF_W-1:0]           o_next
);

    logic [WIN_BYTES-1:0] reach;

    // Build the reach vector from the first byte toward the last.
    always_comb begin
        logic [WIN_BYTES-1:0] r;
        r = '0;
        for (int p = 0; p < WIN_BYTES; p++) begin
            r[p] = (int'(i_carry) == p);
            for (int k = 1; k <= MAX_LEN; k++) begin
                if (k <= p) begin
                    if (r[p-k] && i_full[p-k] &&
                        (i_lens[(p-k)*LEN_W +: LEN_W] == LEN_W'(k))) begin
                        r[p] = 1'b1;
                    end
                end
            end
        end
        reach = r;
    end

    assign o_start = reach & i_full;

    // Derive the resume offset from the reached position that leaves the window.
    always_comb begin
        int end_pos;
        o_split = 1'b0;
        o_next  = '0;
        for (int p = 0; p < WIN_BYTES; p++) begin
            end_pos = p + int'(i_lens[p*LEN_W +: LEN_W]);
            if (reach[p] && i_full[p] && (end_pos >= WIN_BYTES)) begin
                o_next = OFF_W'(end_pos - WIN_BYTES);
            end
            if (reach[p] && !i_full[p]) begin
                o_split = 1'b1;
                o_next  = OFF_W'(WIN_BYTES - p);
            end
        end
    end

endmodule

// File: rtl/ild_top.sv
// Module: ild_top
// Single-cycle parallel instruction length decoder for one byte window.
// Every position gets a speculative length from ild_byte_len, ild_chain picks
// the real starts, and the results are registered with the valid strobe.
// Assumes HDR_MAX <= WIN_BYTES and an entry offset narrower than the window.
module ild_top
    import ild_pkg::*;
#(
    parameter int WIN_BYTES = 64,
    parameter int HDR_MAX   = 4,
    parameter int PAY_W     = 2,
    localparam int MAX_LEN  = HDR_MAX << PAY_W,
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int OFF_W    = $clog2(MAX_LEN)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           i_valid,
    input  logic [WIN_BYTES*ILD_BYTE_W-1:0] i_bytes,
    input  logic [OFF_W-1:0]               i_carry_off,
    output logic                           o_valid,
    output logic [WIN_BYTES-1:0]           o_start_mask,
    output logic [WIN_BYTES*LEN_W-1:0]     o_len,
    output logic [OFF_W-1:0]               o_next_off,
    output logic                           o_split
);

    localparam int PAD_W = (WIN_BYTES + HDR_MAX) * ILD_BYTE_W;

    logic [PAD_W-1:0]               padded;
    logic [WIN_BYTES*LEN_W-1:0]     spec_len;
    logic [WIN_BYTES-1:0]           spec_full;
    logic [WIN_BYTES-1:0]           start_c;
    logic                           split_c;
    logic [OFF_W-1:0]               next_c;
    logic [WIN_BYTES*LEN_W-1:0]     kept_len;

    // Extend the window with zero bytes so every header slice is in range.
    assign padded = {{(HDR_MAX*ILD_BYTE_W){1'b0}}, i_bytes};

    for (genvar p = 0; p < WIN_BYTES; p++) begin : g_pos
        localparam int VIS_P = ((WIN_BYTES - p) >= HDR_MAX) ? HDR_MAX : (WIN_BYTES - p);

        ild_byte_len #(
            .HDR_MAX (HDR_MAX),
            .PAY_W   (PAY_W),
            .VIS     (VIS_P),
            .LEN_W   (LEN_W)
        ) u_len (
            .i_hdr  (padded[p*ILD_BYTE_W +: HDR_MAX*ILD_BYTE_W]),
            .o_len  (spec_len[p*LEN_W +: LEN_W]),
            .o_full (spec_full[p])
        );

        // Keep the length only where a real start was resolved.
        assign kept_len[p*LEN_W +: LEN_W] =
            start_c[p] ? spec_len[p*LEN_W +: LEN_W] : '0;
    end

    ild_chain #(
        .WIN_BYTES (WIN_BYTES),
        .MAX_LEN   (MAX_LEN),
        .LEN_W     (LEN_W),
        .OFF_W     (OFF_W)
    ) u_chain (
        .i_lens  (spec_len),
        .i_full  (spec_full),
        .i_carry (i_carry_off),
        .o_start (start_c),
        .o_split (split_c),
        .o_next  (next_c)
    );

    // Register valid every cycle; capture results only for a valid window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid      <= 1'b0;
            o_start_mask <= '0;
            o_len        <= '0;
            o_next_off   <= '0;
            o_split      <= 1'b0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_start_mask <= start_c;
                o_len        <= kept_len;
                o_next_off   <= next_c;
                o_split      <= split_c;
            end
        end
    end

endmodule

// File: rtl/ild_chk.sv
// Module: ild_chk
// Assertion checker for ild_top, attached by bind. Relates the registered
// outputs to the inputs of the previous cycle and checks per-position rules.
module ild_chk #(
    parameter int WIN_BYTES = 64,
    parameter int HDR_MAX   = 4,
    parameter int PAY_W     = 2,
    localparam int MAX_LEN  = HDR_MAX << PAY_W,
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int OFF_W    = $clog2(MAX_LEN),
    localparam int PW       = $clog2(WIN_BYTES)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       i_valid,
    input logic [OFF_W-1:0]           i_carry_off,
    input logic                       o_valid,
    input logic [WIN_BYTES-1:0]       o_start_mask,
    input logic [WIN_BYTES*LEN_W-1:0] o_len,
    input logic [OFF_W-1:0]           o_next_off,
    input logic                       o_split
);

    logic [PW-1:0]        carry_idx;
    logic [PW-1:0]        split_pos;
    logic [WIN_BYTES-1:0] below_carry;

    assign carry_idx   = PW'(i_carry_off);
    assign split_pos   = PW'(WIN_BYTES - int'(o_next_off));
    assign below_carry = ({{(WIN_BYTES-1){1'b0}}, 1'b1} << i_carry_off) - 1'b1;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> !o_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> ($stable(o_start_mask) && $stable(o_next_off) && $stable(o_split))); // R7
    AST_FIRST_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> (o_start_mask[$past(carry_idx)] || o_split)); // R2
    AST_NONE_BELOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> ((o_start_mask & $past(below_carry)) == '0)); // R2
    AST_SPLIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        o_split |-> (o_next_off != '0 && o_next_off < OFF_W'(HDR_MAX))); // R6
    AST_SPLIT_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
        o_split |-> !o_start_mask[split_pos]); // R6

    for (genvar p = 0; p < WIN_BYTES; p++) begin : g_pos_chk
        AST_LEN_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !o_start_mask[p] |-> (o_len[p*LEN_W +: LEN_W] == '0)); // R4
        AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            o_start_mask[p] |-> (o_len[p*LEN_W +: LEN_W] != '0 &&
                                 o_len[p*LEN_W +: LEN_W] <= LEN_W'(MAX_LEN))); // R1
    end

endmodule

bind ild_top ild_chk #(
    .WIN_BYTES (WIN_BYTES),
    .HDR_MAX   (HDR_MAX),
    .PAY_W     (PAY_W)
) u_ild_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_valid      (i_valid),
    .i_carry_off  (i_carry_off),
    .o_valid      (o_valid),
    .o_start_mask (o_start_mask),
    .o_len        (o_len),
    .o_next_off   (o_next_off),
    .o_split      (o_split)
);

// File: tb/tb_ild_top.sv
`timescale 1ns/1ps
// Bench for ild_top: a sequential one-instruction-at-a-time reference model,
// compared against the outputs on every clock.
module tb_ild_top;
    localparam int W  = 64;
    localparam int LW = 5;
    localparam int OW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              i_valid = 1'b0;
    logic [W*8-1:0]    i_bytes = '0;
    logic [OW-1:0]     i_carry_off = '0;
    logic              o_valid;
    logic [W-1:0]      o_start_mask;
    logic [W*LW-1:0]   o_len;
    logic [OW-1:0]     o_next_off;
    logic              o_split;

    ild_top dut (
        .clk (clk), .rst_n (rst_n), .i_valid (i_valid), .i_bytes (i_bytes),
        .i_carry_off (i_carry_off), .o_valid (o_valid), .o_start_mask (o_start_mask),
        .o_len (o_len), .o_next_off (o_next_off), .o_split (o_split)
    );

    always #2.5 clk = ~clk;

    logic [7:0]      wb [W];
    logic [W-1:0]    exp_mask = '0;
    int              exp_len [W];
    int              exp_next = 0;
    bit              exp_split = 1'b0;
    bit              exp_valid = 1'b0;
    int              n_checks = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference: decode one instruction after another from the entry offset.
    task automatic model(input int carry);
        int p;
        exp_mask  = '0;
        exp_split = 1'b0;
        for (int i = 0; i < W; i++) exp_len[i] = 0;
        p = carry;
        while (p < W) begin
            int  len = 0;
            bit  cut = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (p + k >= W) begin cut = 1'b1; break; end
                len += 1 + int'(wb[p+k][1:0]);
                if (k == 3 || !wb[p+k][7]) break;
            end
            if (cut) begin
                exp_split = 1'b1;
                exp_next  = W - p;
                break;
            end
            exp_mask[p] = 1'b1;
            exp_len[p]  = len;
            p += len;
        end
        if (!exp_split) exp_next = p - W;
    endtask

    task automatic compare();
        check(o_valid == exp_valid, "R7", "o_valid", o_valid, exp_valid);
        check(o_start_mask == exp_mask, "R3", "o_start_mask", o_start_mask, exp_mask);
        for (int i = 0; i < W; i++) begin
            if (o_len[i*LW +: LW] != LW'(exp_len[i])) begin
                check(1'b0, "R4", $sformatf("o_len[%0d]", i), o_len[i*LW +: LW], exp_len[i]);
            end
        end
        check(1'b1, "R4", "o_len", 0, 0);
        check(o_split == exp_split, "R6", "o_split", o_split, exp_split);
        check(int'(o_next_off) == exp_next, "R5", "o_next_off", o_next_off, exp_next);
    endtask

    task automatic step(input bit v, input int carry);
        @(negedge clk);
        compare();
        for (int i = 0; i < W; i++) i_bytes[i*8 +: 8] = wb[i];
        i_valid     = v;
        i_carry_off = OW'(carry);
        if (v) model(carry);
        exp_valid = v;
    endtask

    task automatic fill(input logic [7:0] val);
        for (int i = 0; i < W; i++) wb[i] = val;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        fill(8'h00);
        repeat (3) @(negedge clk);
        // R8: outputs are zero during reset.
        compare();
        check(o_start_mask == '0 && o_len == '0 && !o_valid, "R8", "reset outputs",
              o_start_mask, 0);
        rst_n = 1'b1;

        // R2/R3: all zero bytes, every position from the entry offset is a start.
        fill(8'h00);
        step(1, 0);
        step(1, 9);
        step(1, 15);

        // R5: maximal 16-byte instructions for several entry offsets.
        fill(8'h83);
        step(1, 0);
        step(1, 5);
        step(1, 15);

        // R1: mixed contributions 2+3+4 = 9 at byte 0.
        fill(8'h00);
        wb[0] = 8'h81; wb[1] = 8'h82; wb[2] = 8'h03;
        step(1, 0);
        step(0, 0);
        check(o_len[0 +: LW] == LW'(9), "R1", "mixed header length", o_len[0 +: LW], 9);

        // R1: continuation on the fourth header byte has no effect.
        fill(8'h00);
        wb[0] = 8'h80; wb[1] = 8'h80; wb[2] = 8'h80; wb[3] = 8'h80;
        step(1, 0);
        step(0, 0);
        check(o_len[0 +: LW] == LW'(4) && o_start_mask[4], "R1", "fourth byte capped",
              o_len[0 +: LW], 4);

        // R6: header cut off at byte 62, two header bytes present.
        fill(8'h00);
        wb[62] = 8'h80; wb[63] = 8'h80;
        step(1, 0);
        step(0, 3);
        check(o_split && o_next_off == OW'(2) && !o_start_mask[62], "R6", "cut header",
              o_next_off, 2);

        // R7: idle cycles hold the previous results.
        step(0, 7);
        step(0, 1);

        // Random windows with sparse and dense continuation bits.
        for (int n = 0; n < 500; n++) begin
            bit dense = (n % 3 == 0);
            for (int i = 0; i < W; i++) begin
                wb[i] = 8'($urandom);
                if (!dense && ($urandom % 4 != 0)) wb[i][7] = 1'b0;
            end
            step(($urandom % 5) != 0, int'($urandom % 16));
        end
        step(0, 0);
        step(0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule